// File: doc/BRIEF.md
# UART transmit queue with line break

This block is the transmit side of a high-speed UART. Software writes characters one at a time into a 64-entry queue through a small register port. A downstream serializer takes the oldest character through a valid/ready handshake and handles bit timing. The current occupancy can be read back at any time. When the queue drains to a programmable low-water mark, the block raises an interrupt so software can refill it.

Software can also raise the transmit interrupt status on demand, and clears it by writing a one. A break bit in the control register drives the serial line low and halts the queue until the bit is cleared. Queued characters are held during a break and sent afterwards in their original order.

Register port: one access per cycle while `req_i` is high. `we_i` selects a write. Reads are combinational on `addr_i`. Word index 0 is the data port, 1 is the level register, 2 is the status register and 3 is the control register.

Top module: `uart_txq`

## Requirements
- R1: A write to index 0 pushes `wdata_i[7:0]` into the queue. While the queue is non-empty and no break is active, `ser_valid_o` is high and `ser_data_o` shows the oldest entry. An entry is removed on each cycle in which `ser_ready_i` is also high, so characters leave in the order they were written.
- R2: Reading index 1 returns the queue occupancy (0 to 64) in bits 15:8 and zero in all other bits. A value of 0 means the transmitter is empty.
- R3: A write to index 0 while the queue holds 64 entries is dropped. The occupancy stays at 64 and the stored characters are unchanged.
- R4: Control bits 1:0 select the low-water mark: code 0 selects 0 entries (empty), code 1 selects 4, code 2 selects 8 and code 3 selects 16. Reading index 3 returns the threshold in bits 1:0, the interrupt enable in bit 5 and the break bit in bit 8, with all other bits zero.
- R5: The status bit (index 2, bit 0) is set on the clock edge at which the occupancy goes from above the low-water mark to at or below it. Pushes never set it. A pop that stays above the mark, or a pop that starts at or below the mark, does not set it.
- R6: Writing index 2 with bit 0 high clears the status bit. Writing index 2 with bit 6 high sets it.
- R7: If a set and a clear reach the status bit in the same cycle, the set wins. This holds whether the set comes from the occupancy crossing or from bit 6.
- R8: `irq_o` is high exactly when the status bit is set and control bit 5 (interrupt enable) is set.
- R9: While control bit 8 (break) is set, `txd_o` is low, `ser_valid_o` is low and no entry leaves the queue. Once the bit is cleared, transmission resumes with the oldest held character.
- R10: With break clear, `txd_o` is high, and the line idles high when the queue is empty.
- R11: After reset the queue is empty, the status bit and all control fields are zero, `txd_o` is high and `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | Write when high, read when low |
| addr_i | input | 2 | Register word index |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for the addressed register |
| ser_valid_o | output | 1 | A character is offered to the serializer |
| ser_data_o | output | 8 | Oldest queued character |
| ser_ready_i | input | 1 | Serializer accepts the offered character |
| txd_o | output | 1 | Serial line level (idle/break owner) |
| irq_o | output | 1 | Transmit interrupt request |

## Verification
Two events can reach the status bit in the same cycle: a serializer pop that takes the occupancy across the low-water mark, and a software write that clears the status bit. The bench fills the queue one entry above a mark of 4, sets the status, and then in a single cycle raises `ser_ready_i` and writes 1 to the status register. It passes only if the status reads 1 afterwards and the level reads 4. A one-cycle write carrying both the clear bit and the set bit is judged by the same rule.

// File: rtl/uart_txq_pkg.sv
package uart_txq_pkg;

  typedef enum logic [1:0] {
    REG_DATA  = 2'd0,
    REG_LEVEL = 2'd1,
    REG_STAT  = 2'd2,
    REG_CTRL  = 2'd3
  } reg_sel_e;

  localparam int STAT_FLAG_BIT = 0;
  localparam int STAT_SET_BIT  = 6;
  localparam int CTRL_IE_BIT   = 5;
  localparam int CTRL_BRK_BIT  = 8;
  localparam int LVL_LSB       = 8;
  localparam int LVL_W         = 8;

  function automatic logic [4:0] low_water(input logic [1:0] sel);
    case (sel)
      2'd0:    low_water = 5'd0;
      2'd1:    low_water = 5'd4;
      2'd2:    low_water = 5'd8;
      default: low_water = 5'd16;
    endcase
  endfunction

endpackage

// File: rtl/txq_fifo.sv
module txq_fifo #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] head_o,
  output logic             empty_o,
  output logic             full_o,
  output logic [CW-1:0]    cnt_o,
  output logic [CW-1:0]    cnt_next_o
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr_q, rd_ptr_q;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             push_ok, pop_ok;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    ptr_inc = (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign push_ok = push_i && !full_o;   // full: drop, never overwrite
  assign pop_ok  = pop_i && !empty_o;

  always_comb begin
    cnt_d = cnt_q;
    if (push_ok && !pop_ok) cnt_d = cnt_q + 1'b1;
    else if (!push_ok && pop_ok) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_ok) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (pop_ok)  rd_ptr_q <= ptr_inc(rd_ptr_q);
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_ok) mem[wr_ptr_q] <= data_i;
  end

  assign head_o     = mem[rd_ptr_q];
  assign cnt_o      = cnt_q;
  assign cnt_next_o = cnt_d;

  a_r3_full_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && !pop_i) |=> (cnt_q == CW'(DEPTH)));

  a_r2_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));

endmodule

// File: rtl/txq_irq.sv
module txq_irq
  import uart_txq_pkg::*;
#(
  parameter int CW = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] cnt_i,
  input  logic [CW-1:0] cnt_next_i,
  input  logic [1:0]    thr_sel_i,
  input  logic          sw_clr_i,
  input  logic          sw_set_i,
  output logic          flag_o
);

  logic [CW-1:0] mark;
  logic          drop_hit, flag_q;

  assign mark     = CW'(low_water(thr_sel_i));
  assign drop_hit = (cnt_i > mark) && (cnt_next_i <= mark);

  // set sources win over the software clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    flag_q <= 1'b0;
    else if (drop_hit || sw_set_i)  flag_q <= 1'b1;
    else if (sw_clr_i)              flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  a_r5_drop_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i > mark && cnt_next_i <= mark) |=> flag_q);

  a_r6_clear_works: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_clr_i && !sw_set_i && !(cnt_i > mark && cnt_next_i <= mark)) |=> !flag_q);

  a_r7_set_over_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_clr_i && sw_set_i) |=> flag_q);

endmodule

// File: rtl/txq_line.sv
module txq_line (
  input  logic brk_i,
  input  logic empty_i,
  input  logic ser_ready_i,
  output logic ser_valid_o,
  output logic pop_o,
  output logic txd_o
);

  assign ser_valid_o = !empty_i && !brk_i;
  assign pop_o       = ser_valid_o && ser_ready_i;
  assign txd_o       = !brk_i;

endmodule

// File: rtl/uart_txq.sv
module uart_txq
  import uart_txq_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [1:0]        addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              ser_valid_o,
  output logic [DATA_W-1:0] ser_data_o,
  input  logic              ser_ready_i,
  output logic              txd_o,
  output logic              irq_o
);

  logic          wr_data, wr_stat, wr_ctrl;
  logic [1:0]    thr_sel_q;
  logic          ie_q, brk_q;
  logic          pop, empty, full, flag;
  logic [CW-1:0] cnt, cnt_next;

  assign wr_data = req_i && we_i && (addr_i == REG_DATA);
  assign wr_stat = req_i && we_i && (addr_i == REG_STAT);
  assign wr_ctrl = req_i && we_i && (addr_i == REG_CTRL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      thr_sel_q <= 2'd0;
      ie_q      <= 1'b0;
      brk_q     <= 1'b0;
    end else if (wr_ctrl) begin
      thr_sel_q <= wdata_i[1:0];
      ie_q      <= wdata_i[CTRL_IE_BIT];
      brk_q     <= wdata_i[CTRL_BRK_BIT];
    end
  end

  txq_fifo #(.DEPTH(DEPTH), .WIDTH(DATA_W)) u_fifo (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (wr_data),
    .data_i     (wdata_i[DATA_W-1:0]),
    .pop_i      (pop),
    .head_o     (ser_data_o),
    .empty_o    (empty),
    .full_o     (full),
    .cnt_o      (cnt),
    .cnt_next_o (cnt_next)
  );

  txq_irq #(.CW(CW)) u_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cnt_i      (cnt),
    .cnt_next_i (cnt_next),
    .thr_sel_i  (thr_sel_q),
    .sw_clr_i   (wr_stat && wdata_i[STAT_FLAG_BIT]),
    .sw_set_i   (wr_stat && wdata_i[STAT_SET_BIT]),
    .flag_o     (flag)
  );

  txq_line u_line (
    .brk_i       (brk_q),
    .empty_i     (empty),
    .ser_ready_i (ser_ready_i),
    .ser_valid_o (ser_valid_o),
    .pop_o       (pop),
    .txd_o       (txd_o)
  );

  assign irq_o = flag && ie_q;

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      REG_LEVEL: rdata_o[LVL_LSB +: LVL_W] = LVL_W'(cnt);
      REG_STAT:  rdata_o[STAT_FLAG_BIT]    = flag;
      REG_CTRL: begin
        rdata_o[1:0]          = thr_sel_q;
        rdata_o[CTRL_IE_BIT]  = ie_q;
        rdata_o[CTRL_BRK_BIT] = brk_q;
      end
      default: rdata_o = '0;
    endcase
  end

  a_r9_brk_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (brk_q && !wr_data) |=> (cnt == $past(cnt)));

  a_r1_valid_nonempty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ser_valid_o |-> (cnt != '0));

  a_r10_idle_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!brk_q && !wr_ctrl) |=> txd_o);

endmodule

// File: tb/uart_txq_bench.sv
module uart_txq_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0, ser_ready = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0, rdata;
  logic        ser_valid, txd, irq;
  logic [7:0]  ser_data;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_txq u_uart_txq (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .ser_valid_o(ser_valid),
    .ser_data_o(ser_data), .ser_ready_i(ser_ready), .txd_o(txd), .irq_o(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic level(output int n);
    logic [31:0] d;
    rd(2'd1, d); n = int'(d[15:8]);
  endtask

  task automatic stat(output logic s);
    logic [31:0] d;
    rd(2'd2, d); s = d[0];
  endtask

  task automatic pop1();
    ser_ready = 1'b1; @(posedge clk); @(negedge clk); ser_ready = 1'b0;
  endtask

  task automatic drain();
    int n;
    level(n);
    while (n > 0) begin pop1(); level(n); end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(2'd1, d); check("R11 level after reset", d, 0);
    rd(2'd2, d); check("R11 status after reset", d, 0);
    rd(2'd3, d); check("R11 ctrl after reset", d, 0);
    check("R11 txd after reset", txd, 1);
    check("R11 irq after reset", irq, 0);
    check("R1 valid low when empty", ser_valid, 0);
  endtask

  task automatic t_order();
    logic [31:0] d;
    wr(2'd0, 32'hA1); wr(2'd0, 32'hB2); wr(2'd0, 32'hC3);
    rd(2'd1, d); check("R2 level field 3", d, 32'h0300);
    check("R1 valid with data", ser_valid, 1);
    check("R1 head first", ser_data, 8'hA1);
    pop1(); check("R1 head second", ser_data, 8'hB2);
    pop1(); check("R1 head third", ser_data, 8'hC3);
    pop1(); check("R1 valid after drain", ser_valid, 0);
    rd(2'd1, d); check("R2 empty level 0", d, 0);
  endtask

  task automatic t_full();
    int n;
    for (int i = 0; i < 64; i++) wr(2'd0, 32'(i));
    level(n); check("R2 level 64", n, 64);
    wr(2'd0, 32'hEE);
    level(n); check("R3 level stays 64", n, 64);
    ser_ready = 1'b1;
    for (int i = 0; i < 64; i++) begin
      if (ser_data !== 8'(i)) check("R3 stored data intact", ser_data, 8'(i));
      @(posedge clk); @(negedge clk);
    end
    checks++;
    ser_ready = 1'b0;
    level(n); check("R3 empty after 64 pops", n, 0);
  endtask

  task automatic t_thresh(input logic [1:0] code, input int mark);
    logic s;
    wr(2'd3, 32'(code));
    wr(2'd2, 32'h1);
    for (int i = 0; i < mark + 2; i++) wr(2'd0, 32'h55);
    stat(s); check("R5 pushes do not set", s, 0);
    pop1(); stat(s); check("R5 pop above mark no set", s, 0);
    pop1(); stat(s); check("R4 R5 crossing sets status", s, 1);
    if (mark > 0) begin
      wr(2'd2, 32'h1);
      pop1(); stat(s); check("R5 pop below mark no set", s, 0);
    end
    drain();
    wr(2'd2, 32'h1);
  endtask

  task automatic t_sw_status();
    logic s;
    wr(2'd3, 32'h0);
    wr(2'd2, 32'h40); stat(s); check("R6 software set", s, 1);
    check("R8 irq masked", irq, 0);
    wr(2'd3, 32'h20); check("R8 irq enabled", irq, 1);
    wr(2'd2, 32'h01); stat(s); check("R6 w1c clears", s, 0);
    check("R8 irq drops with status", irq, 0);
    wr(2'd2, 32'h41); stat(s); check("R7 set+clear same write", s, 1);
    check("R8 irq follows", irq, 1);
    wr(2'd2, 32'h01);
    wr(2'd3, 32'h0);
  endtask

  task automatic t_hw_vs_clear();
    logic s; int n;
    wr(2'd3, 32'h1);
    for (int i = 0; i < 5; i++) wr(2'd0, 32'h11);
    wr(2'd2, 32'h40);
    ser_ready = 1'b1; req = 1'b1; we = 1'b1; addr = 2'd2; wdata = 32'h1;
    @(posedge clk); @(negedge clk);
    ser_ready = 1'b0; req = 1'b0; we = 1'b0;
    level(n); check("R7 pop happened", n, 4);
    stat(s); check("R7 crossing beats clear", s, 1);
    drain(); wr(2'd2, 32'h1); wr(2'd3, 32'h0);
  endtask

  task automatic t_break();
    int n; logic [31:0] d;
    wr(2'd3, 32'h100);
    rd(2'd3, d); check("R4 ctrl readback brk", d, 32'h100);
    wr(2'd0, 32'h5A); wr(2'd0, 32'hA5);
    ser_ready = 1'b1;
    check("R9 txd low in break", txd, 0);
    check("R9 valid low in break", ser_valid, 0);
    repeat (4) @(negedge clk);
    level(n); check("R9 queue held", n, 2);
    check("R9 txd still low", txd, 0);
    wr(2'd3, 32'h0);
    check("R10 txd high after break", txd, 1);
    check("R9 resumes valid", ser_valid, 1);
    check("R9 oldest first", ser_data, 8'h5A);
    @(posedge clk); @(negedge clk);
    check("R9 second char", ser_data, 8'hA5);
    @(posedge clk); @(negedge clk);
    ser_ready = 1'b0;
    level(n); check("R10 drained", n, 0);
    check("R10 idle high when empty", txd, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_order();
    t_full();
    t_thresh(2'd0, 0);
    t_thresh(2'd1, 4);
    t_thresh(2'd2, 8);
    t_thresh(2'd3, 16);
    t_sw_status();
    t_hw_vs_clear();
    t_break();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; fails++;
    $display("FAIL watchdog all actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule